// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus side of a serial memory on a two-wire bus. SCL and SDA are resynchronised to a fast system clock. The block recognises Start and Stop conditions and assembles the control byte. When the seven address bits of that byte match the configured device address, it acknowledges. After that it either passes each received byte to a memory controller or fetches each byte it has to send. SDA is driven open-drain: the block only ever pulls the line low or lets it go.

The memory controller sees two simple strobes. A one-cycle pulse carries each acknowledged write byte, and a flag marks the first byte after the control byte, which is the word address. A one-cycle request asks for the next byte to transmit, and that byte is captured in the same cycle. A third pulse reports the Stop that closes an addressed transfer, so the controller can commit a write. While the memory side signals that an internal programming cycle is running, the block gives no acknowledge at all, not even for its own address.

Top module: `i2cs_front`

## Requirements
- R1: After reset, and for any bits clocked before the first Start, `sda_low_o` stays 0 and `rx_valid_o`, `tx_req_o` and `stop_o` stay 0.
- R2: A Start is SDA falling while SCL is high. It begins reception of the control byte. Bits are taken on SCL rising edges, most significant bit first.
- R3: The upper seven bits of the control byte are compared with `DEV_ADDR` (default 7'b1010000). Bit 0 selects the direction: 1 is read, 0 is write. On a match with `busy_i` low at the falling edge that ends the eighth bit, the block pulls SDA low from that edge until the falling edge of the ninth clock.
- R4: A control byte with a different address gets no acknowledge. No strobe follows until the next Start or Stop.
- R5: If `busy_i` is high when an acknowledge would be given, for a control byte or for a write data byte, SDA stays released and no `rx_valid_o` is produced. The block then ignores the bus until the next Start or Stop.
- R6: In a write, every data byte is acknowledged and `rx_valid_o` pulses for one cycle with `rx_data_o`. `rx_first_o` is 1 only with the first data byte after the control byte.
- R7: In a read, `tx_req_o` pulses for one cycle at the end of the address acknowledge, and `tx_data_i` is captured in that cycle. The byte is driven most significant bit first, and a 0 bit is sent by pulling SDA low.
- R8: A read byte that the master acknowledges (SDA low on the ninth clock) triggers another `tx_req_o` and the next byte. After a byte the master does not acknowledge, SDA stays released and no further `tx_req_o` comes until a new Start.
- R9: A Stop is SDA rising while SCL is high. It returns the block to idle and releases SDA. `stop_o` pulses once only if the transfer since the last Start had its control byte acknowledged.
- R10: A repeated Start in the middle of a byte discards the partial byte and restarts control-byte reception.
- R11: `sda_low_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | Memory is in an internal programming cycle |
| rx_valid_o | output | 1 | One-cycle strobe: write byte received and acknowledged |
| rx_data_o | output | 8 | Received byte, valid with `rx_valid_o` |
| rx_first_o | output | 1 | Marks the first data byte after the control byte |
| tx_req_o | output | 1 | One-cycle request for the next byte to send |
| tx_data_i | input | 8 | Byte to send, captured while `tx_req_o` is high |
| stop_o | output | 1 | One-cycle pulse on a Stop that closes an addressed transfer |

## Verification
The hardest states to reach from the ports are the ones the bus only shows in the middle of a byte or after the master has given up on a read. One is a repeated Start arriving after only a few bits. The other is SCL still toggling after the master has declined a read byte. The bench reaches both by driving the bus line by line from bit-level tasks. It cuts a control byte short with a fresh Start, and it keeps clocking after a NACK. It then checks that the line stays high and that no new byte request appears. It also raises `busy_i` partway through a write, so that the refusal lands on a data byte rather than on the address.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    // synchronised bus events, all valid for one system clock
    typedef struct packed {
        logic sda;    // synchronised data line
        logic rise;   // SCL rising edge
        logic fall;   // SCL falling edge
        logic start;  // SDA falls while SCL high
        logic stop;   // SDA rises while SCL high
    } bus_ev_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } st_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
        return b[BYTE_W-1:1] == a;
    endfunction

endpackage

// File: rtl/i2cs_sampler.sv
module i2cs_sampler
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_s,
    output bus_ev_t ev
);
    localparam int N_LINES = 2;  // index 1 = SCL, index 0 = SDA

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] cur;
    logic [N_LINES-1:0] old;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end
        assign cur[g] = chain[STAGES-1];
        assign old[g] = last;
    end

    assign scl_s    = cur[1];
    assign ev.sda   = cur[0];
    assign ev.rise  = cur[1] & ~old[1];
    assign ev.fall  = ~cur[1] & old[1];
    assign ev.start = cur[1] & old[1] & old[0] & ~cur[0];
    assign ev.stop  = cur[1] & old[1] & ~old[0] & cur[0];

endmodule

// File: rtl/i2cs_shreg.sv
module i2cs_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         sample,
    input  logic         sda,
    output logic [W-1:0] q,
    output logic         full
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    assign full = (cnt == CW'(W));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q   <= '0;
            cnt <= '0;
        end else if (load) begin
            q   <= ld_val;
            cnt <= '0;
        end else if (sample && !full) begin
            // the line value is shifted in for both directions
            q   <= {q[W-2:0], sda};
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b1010000
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] q,
    input  logic              full,
    input  logic              busy_i,
    input  logic              tx_msb_i,
    output logic              sr_clr,
    output logic              sr_load,
    output logic              sda_low_o,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_first_o,
    output logic              tx_req_o,
    output logic              stop_o
);
    st_t  st;
    logic rw;
    logic active;
    logic first;
    logic mack;

    // shift register control and the byte request are decided combinationally
    always_comb begin
        sr_clr   = 1'b0;
        sr_load  = 1'b0;
        tx_req_o = 1'b0;
        if (!ev.stop) begin
            if (ev.start) begin
                sr_clr = 1'b1;
            end else if (ev.fall) begin
                case (st)
                    ST_CACK: begin
                        if (rw) begin
                            sr_load  = 1'b1;
                            tx_req_o = 1'b1;
                        end else begin
                            sr_clr = 1'b1;
                        end
                    end
                    ST_WACK: sr_clr = 1'b1;
                    ST_RACK: begin
                        if (mack) begin
                            sr_load  = 1'b1;
                            tx_req_o = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            sda_low_o  <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
            rx_first_o <= 1'b0;
            stop_o     <= 1'b0;
            rw         <= 1'b0;
            active     <= 1'b0;
            first      <= 1'b0;
            mack       <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            rx_first_o <= 1'b0;
            stop_o     <= 1'b0;
            if (ev.stop) begin
                st        <= ST_IDLE;
                sda_low_o <= 1'b0;
                stop_o    <= active;
                active    <= 1'b0;
            end else if (ev.start) begin
                st        <= ST_CTRL;
                sda_low_o <= 1'b0;
                active    <= 1'b0;
            end else begin
                if (ev.rise && st == ST_RACK) begin
                    mack <= ~ev.sda;
                end
                if (ev.fall) begin
                    case (st)
                        ST_CTRL: begin
                            if (full) begin
                                if (addr_hit(q, DEV_ADDR) && !busy_i) begin
                                    sda_low_o <= 1'b1;
                                    rw        <= q[0];
                                    active    <= 1'b1;
                                    st        <= ST_CACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                        end
                        ST_CACK: begin
                            if (rw) begin
                                sda_low_o <= ~tx_msb_i;
                                st        <= ST_RDATA;
                            end else begin
                                sda_low_o <= 1'b0;
                                first     <= 1'b1;
                                st        <= ST_WDATA;
                            end
                        end
                        ST_WDATA: begin
                            if (full) begin
                                if (!busy_i) begin
                                    sda_low_o  <= 1'b1;
                                    rx_valid_o <= 1'b1;
                                    rx_data_o  <= q;
                                    rx_first_o <= first;
                                    first      <= 1'b0;
                                    st         <= ST_WACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                        end
                        ST_WACK: begin
                            sda_low_o <= 1'b0;
                            st        <= ST_WDATA;
                        end
                        ST_RDATA: begin
                            if (full) begin
                                sda_low_o <= 1'b0;
                                st        <= ST_RACK;
                            end else begin
                                sda_low_o <= ~q[BYTE_W-1];
                            end
                        end
                        ST_RACK: begin
                            if (mack) begin
                                sda_low_o <= ~tx_msb_i;
                                st        <= ST_RDATA;
                            end else begin
                                sda_low_o <= 1'b0;
                                st        <= ST_SKIP;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/i2cs_front.sv
module i2cs_front
    import i2cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'b1010000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_low_o,
    input  logic              busy_i,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_first_o,
    output logic              tx_req_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              stop_o
);
    bus_ev_t           ev;
    logic              scl_s;
    logic              stop_ev;
    logic              sr_clr;
    logic              sr_load;
    logic              sr_full;
    logic [BYTE_W-1:0] sr_q;

    assign stop_ev = ev.stop;

    i2cs_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .ev    (ev)
    );

    i2cs_shreg #(.W(BYTE_W)) u_shreg (
        .clk    (clk),
        .rst    (rst),
        .clr    (sr_clr),
        .load   (sr_load),
        .ld_val (tx_data_i),
        .sample (ev.rise),
        .sda    (ev.sda),
        .q      (sr_q),
        .full   (sr_full)
    );

    i2cs_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .q          (sr_q),
        .full       (sr_full),
        .busy_i     (busy_i),
        .tx_msb_i   (tx_data_i[BYTE_W-1]),
        .sr_clr     (sr_clr),
        .sr_load    (sr_load),
        .sda_low_o  (sda_low_o),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .rx_first_o (rx_first_o),
        .tx_req_o   (tx_req_o),
        .stop_o     (stop_o)
    );

endmodule

// File: rtl/i2cs_front_chk.sv
module i2cs_front_chk (
    input logic clk,
    input logic rst,
    input logic busy_i,
    input logic sda_low_o,
    input logic rx_valid_o,
    input logic rx_first_o,
    input logic tx_req_o,
    input logic stop_o,
    input logic scl_s,
    input logic stop_ev
);
    // R5 / R6: a data strobe only follows a decision taken while not busy
    assert_rx_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(!busy_i));

    // R6: a received byte is always accompanied by the acknowledge
    assert_rx_acked_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> sda_low_o);

    // R6: the first-byte flag never appears without a byte
    assert_first_with_rx_R6: assert property (@(posedge clk) disable iff (rst)
        rx_first_o |-> rx_valid_o);

    // R9: a Stop leaves the line released
    assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_low_o);

    // R11: the drive changes only after SCL has gone low
    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low_o) |-> !$past(scl_s));

    // R7 / R9: strobes toward the memory side never coincide
    assert_strobes_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid_o, tx_req_o, stop_o}));
endmodule

bind i2cs_front i2cs_front_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy_i),
    .sda_low_o  (sda_low_o),
    .rx_valid_o (rx_valid_o),
    .rx_first_o (rx_first_o),
    .tx_req_o   (tx_req_o),
    .stop_o     (stop_o),
    .scl_s      (scl_s),
    .stop_ev    (stop_ev)
);

// File: tb/tb_i2cs_front.sv
module tb_i2cs_front;
    localparam int Q = 10;  // system clocks per quarter SCL period

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, m_scl, m_sda, busy;
    logic       sda_low, rx_valid, rx_first, tx_req, stop_p;
    logic [7:0] rx_data, tx_data;
    wire        sda_line = m_sda & ~sda_low;

    i2cs_front dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_low_o  (sda_low),
        .busy_i     (busy),
        .rx_valid_o (rx_valid),
        .rx_data_o  (rx_data),
        .rx_first_o (rx_first),
        .tx_req_o   (tx_req),
        .tx_data_i  (tx_data),
        .stop_o     (stop_p)
    );

    int   total = 0, fails = 0;
    int   rx_n = 0, tx_n = 0, stop_n = 0;
    logic [7:0] rx_log [32];
    logic       first_log [32];
    bit   done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid && rx_n < 32) begin
                rx_log[rx_n]    = rx_data;
                first_log[rx_n] = rx_first;
                rx_n++;
            end
            if (tx_req) tx_n++;
            if (stop_p) stop_n++;
        end
    end

    // control byte, busy, expected acknowledge
    localparam logic [9:0] VEC [8] = '{
        {8'hA0, 1'b0, 1'b1},
        {8'hA1, 1'b0, 1'b1},
        {8'hA2, 1'b0, 1'b0},
        {8'h20, 1'b0, 1'b0},
        {8'hA0, 1'b1, 1'b0},
        {8'hA1, 1'b1, 1'b0},
        {8'hFF, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b0}
    };

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clock_bit(input logic b, output logic s);
        m_sda = b;  wq();
        m_scl = 1'b1; wq();
        s = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic start_cond();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic stop_cond();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read8(output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, s);
            b = {b[6:0], s};
        end
    endtask

    initial begin
        logic       a, s;
        logic [7:0] d;
        int         base, tbase, sbase;
        rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1; busy = 1'b0; tx_data = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 reset outputs", {sda_low, rx_valid, tx_req, stop_p}, 0);

        // R1: a matching byte with no Start is ignored
        sbase = stop_n;
        m_scl = 1'b0; wq();
        send_byte(8'hA0, a);
        chk("R1 no ack before Start", a, 0);
        stop_cond();
        chk("R9 no stop pulse for unaddressed bus", stop_n - sbase, 0);

        // R2/R3/R4/R5: control byte table
        sbase = stop_n;
        tx_data = 8'h96;
        for (int i = 0; i < 8; i++) begin
            busy = VEC[i][1];
            start_cond();
            send_byte(VEC[i][9:2], a);
            busy = 1'b0;
            chk($sformatf("R3/R4/R5 row %0d ack", i), a, VEC[i][0]);
            if (a && VEC[i][2]) begin
                read8(d);
                clock_bit(1'b1, s);
                chk("R7 table read data", d, 8'h96);
            end
            stop_cond();
        end
        chk("R9 stop pulses for addressed rows", stop_n - sbase, 2);

        // R6: write of three bytes
        base = rx_n; sbase = stop_n;
        start_cond();
        send_byte(8'hA0, a); chk("R3 write address ack", a, 1);
        send_byte(8'h10, a); chk("R6 byte0 ack", a, 1);
        send_byte(8'hAB, a); chk("R6 byte1 ack", a, 1);
        send_byte(8'hCD, a); chk("R6 byte2 ack", a, 1);
        stop_cond();
        chk("R6 rx count", rx_n - base, 3);
        chk("R6 byte0 data", rx_log[base], 8'h10);
        chk("R6 byte0 first flag", first_log[base], 1);
        chk("R6 byte2 data", rx_log[base+2], 8'hCD);
        chk("R6 byte1 first flag", first_log[base+1], 0);
        chk("R9 stop after write", stop_n - sbase, 1);

        // R5: busy rises during a write
        base = rx_n;
        start_cond();
        send_byte(8'hA0, a);
        send_byte(8'h11, a); chk("R5 pre-busy ack", a, 1);
        busy = 1'b1;
        send_byte(8'h22, a); chk("R5 busy data nack", a, 0);
        busy = 1'b0;
        send_byte(8'h44, a); chk("R5 ignored after refusal", a, 0);
        stop_cond();
        chk("R5 only pre-busy byte delivered", rx_n - base, 1);

        // R7/R8: read two bytes, ack then nack
        tbase = tx_n;
        tx_data = 8'hC3;
        start_cond();
        send_byte(8'hA1, a);
        chk("R7 first request", tx_n - tbase, 1);
        read8(d); chk("R7 read byte0", d, 8'hC3);
        tx_data = 8'h3C;
        clock_bit(1'b0, s);
        read8(d); chk("R8 read byte1 after ack", d, 8'h3C);
        clock_bit(1'b1, s);
        read8(d); chk("R8 line released after nack", d, 8'hFF);
        chk("R8 no request after nack", tx_n - tbase, 2);
        stop_cond();

        // R10: repeated Start in the middle of a byte
        base = rx_n;
        start_cond();
        clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b1, s);
        start_cond();
        send_byte(8'hA0, a); chk("R10 ack after restart", a, 1);
        send_byte(8'h33, a);
        stop_cond();
        chk("R10 byte after restart", rx_log[base], 8'h33);
        chk("R10 first flag after restart", first_log[base], 1);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule